// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block sits between a host access port and a network controller. It holds a 16-byte station-address PROM and decides, for every host access, whether the access is served from that PROM, handed on to the controller's register port, or refused. Host accesses come through one of two apertures. The I/O aperture sets the legal access sizes from a word/doubleword mode input. The memory aperture chooses between PROM and registers with a single address bit and applies no size mode.

The host issues a single-cycle request with an aperture select, address, size code, direction and write data. A PROM access or a refused access completes one cycle later with a `done` pulse and read data. A register access is sent out on a request/ready port and is held there until the register side answers. Multi-byte values are little-endian. PROM writes take effect only while the write-enable input is high.

Top module: `sa_prom_decoder`

## Requirements
- R1: On reset the PROM holds the `DEFAULT_ADDR` parameter, with byte i taken from bits [8i+7:8i]. `busy`, `done` and `rp_req` are low.
- R2: Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal (refused, treated as 4 bytes wide). With `dw_mode` low, I/O offsets 0x00-0x0F take byte accesses and 2-byte accesses at even offsets. Every other access there is refused.
- R3: With `dw_mode` high, I/O offsets 0x00-0x0F take only 4-byte accesses whose offset is a multiple of 4.
- R4: A refused read returns ones across the access width and zeros above it (0xFF, 0xFFFF, 0xFFFFFFFF). A refused write changes nothing.
- R5: A PROM write changes bytes only if `prom_we` is high at the clock edge that accepts the request. PROM reads are always served.
- R6: Multi-byte PROM data is little-endian, with byte k at PROM index (offset+k) mod 16. Reads return zeros above the access width.
- R7: In the I/O aperture, 2- and 4-byte accesses at offsets 0x10 and above go to the register port with the offset unchanged. Byte accesses and size code 3 there are refused.
- R8: In the memory aperture (`req_mem`=1), address bit 4 high selects the register port and low selects the PROM. The low 4 bits are the offset in both cases. PROM accesses ignore `dw_mode` and alignment. A byte access to the register half is refused.
- R9: A register access raises `rp_req` the cycle after acceptance and holds it with stable address, size, direction and data until `rp_ready` is sampled high. `done` follows one cycle later, with read data masked to the access width.
- R10: A PROM or refused access gives `done` in the cycle after acceptance. Writes always return zero read data.
- R11: A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_mode | input | 1 | Doubleword I/O mode for the I/O aperture |
| prom_we | input | 1 | PROM write enable |
| req_valid | input | 1 | Host request strobe, one cycle |
| req_mem | input | 1 | 1 = memory aperture, 0 = I/O aperture |
| req_addr | input | ADDR_W | Byte offset within the aperture |
| req_size | input | 2 | Size code (R2) |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 32 | Write data, little-endian |
| busy | output | 1 | Register access outstanding |
| done | output | 1 | Access complete, one cycle |
| rdata | output | 32 | Read data, valid with done |
| rp_req | output | 1 | Register port request |
| rp_addr | output | ADDR_W | Register port offset |
| rp_size | output | 2 | Register port size code |
| rp_write | output | 1 | Register port direction |
| rp_wdata | output | 32 | Register port write data |
| rp_ready | input | 1 | Register port completion |
| rp_rdata | input | 32 | Register port read data |

## Verification
Two events can land on the same clock edge: a PROM write being accepted, and the write-enable input changing. The bench changes `prom_we` at the same time as it presents write requests, with random values, so some edges see enable and request together. A read of the PROM model afterwards confirms that the enable value present at the accepting edge decided the outcome. A second overlap is a new host request during an outstanding register access. It is driven while `rp_ready` is held back, and a later PROM read shows that the request was dropped.

// File: rtl/sa_prom_decoder.sv
module sa_prom_decoder #(
  parameter int ADDR_W = 5,
  parameter logic [127:0] DEFAULT_ADDR = 128'h0000_5757_0000_0000_0000_5634_1200_5452
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dw_mode,
  input  logic              prom_we,
  input  logic              req_valid,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              rp_req,
  output logic [ADDR_W-1:0] rp_addr,
  output logic [1:0]        rp_size,
  output logic              rp_write,
  output logic [31:0]       rp_wdata,
  input  logic              rp_ready,
  input  logic [31:0]       rp_rdata
);
  localparam int NBYTES = 16;

  logic [7:0] prom [NBYTES];
  logic [3:0] idx;
  logic [31:0] mask, prom_rd, rp_mask;
  logic io_low, io_ok, go_fwd, go_prom, accept;

  assign idx    = req_addr[3:0];
  assign io_low = (req_addr >> 4) == '0;
  assign accept = req_valid && !rp_req;
  assign busy   = rp_req;

  assign mask = (req_size == 2'd0) ? 32'h0000_00FF :
                (req_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  assign io_ok = dw_mode ? (req_size == 2'd2 && idx[1:0] == 2'b00)
                         : (req_size == 2'd0 || (req_size == 2'd1 && !idx[0]));

  assign go_prom = req_mem ? (!req_addr[4] && req_size != 2'd3)
                           : (io_low && io_ok);
  assign go_fwd  = (req_size == 2'd1 || req_size == 2'd2) &&
                   (req_mem ? req_addr[4] : !io_low);

  always_comb begin
    prom_rd = '0;
    for (int i = 0; i < 4; i++)
      prom_rd[8*i +: 8] = prom[idx + 4'(i)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_req   <= 1'b0;
      rp_addr  <= '0;
      rp_size  <= '0;
      rp_write <= 1'b0;
      rp_wdata <= '0;
      rp_mask  <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      for (int i = 0; i < NBYTES; i++)
        prom[i] <= DEFAULT_ADDR[8*i +: 8];
    end else begin
      done <= 1'b0;
      if (rp_req) begin
        if (rp_ready) begin
          rp_req <= 1'b0;
          done   <= 1'b1;
          rdata  <= rp_write ? 32'h0 : (rp_rdata & rp_mask);
        end
      end else if (accept) begin
        if (go_fwd) begin
          rp_req   <= 1'b1;
          rp_addr  <= req_mem ? ADDR_W'(idx) : req_addr;
          rp_size  <= req_size;
          rp_write <= req_write;
          rp_wdata <= req_wdata;
          rp_mask  <= mask;
        end else begin
          done  <= 1'b1;
          rdata <= req_write ? 32'h0 : (go_prom ? (prom_rd & mask) : mask);
          if (go_prom && req_write && prom_we)
            for (int i = 0; i < 4; i++)
              if (mask[8*i])
                prom[idx + 4'(i)] <= req_wdata[8*i +: 8];
        end
      end
    end
  end

  logic [8*NBYTES-1:0] prom_flat;
  always_comb
    for (int i = 0; i < NBYTES; i++)
      prom_flat[8*i +: 8] = prom[i];

  AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && !rp_ready |=> rp_req && $stable(rp_addr) && $stable(rp_size) && $stable(rp_wdata)); // R9
  AST_FWD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && rp_ready |=> done && !rp_req); // R9
  AST_NO_BYTE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req |-> rp_size != 2'd0 && rp_size != 2'd3); // R7
  AST_PROM_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prom_flat) |-> $past(prom_we && req_valid && req_write && !rp_req)); // R5
  AST_LOCAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !go_fwd |=> done && !rp_req); // R10
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req && !rp_ready |=> !done); // R11
endmodule

// File: tb/sa_prom_decoder_bench.sv
`timescale 1ns/1ps
module sa_prom_decoder_bench;
  localparam logic [127:0] DEF = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;

  logic clk = 0, rst_n = 0, dw_mode = 0, prom_we = 0;
  logic req_valid = 0, req_mem = 0, req_write = 0, rp_ready = 0;
  logic [4:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0, rp_rdata = 0;
  logic busy, done, rp_req, rp_write;
  logic [31:0] rdata, rp_wdata;
  logic [4:0] rp_addr;
  logic [1:0] rp_size;

  int checks = 0, fails = 0;
  logic [7:0] pm [16];

  always #2 clk = ~clk;

  sa_prom_decoder #(.ADDR_W(5), .DEFAULT_ADDR(DEF)) u_sa_prom_decoder (
    .clk, .rst_n, .dw_mode, .prom_we, .req_valid, .req_mem, .req_addr,
    .req_size, .req_write, .req_wdata, .busy, .done, .rdata, .rp_req,
    .rp_addr, .rp_size, .rp_write, .rp_wdata, .rp_ready, .rp_rdata);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(logic [1:0] sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // 0 = PROM, 1 = forward, 2 = refused
  function automatic int kind(bit mem, logic [4:0] a, logic [1:0] sz, bit dw);
    if (mem) begin
      if (sz == 3) return 2;
      if (a[4]) return (sz == 0) ? 2 : 1;
      return 0;
    end
    if (a[4]) return (sz == 1 || sz == 2) ? 1 : 2;
    if (dw) return (sz == 2 && a[1:0] == 0) ? 0 : 2;
    return (sz == 0 || (sz == 1 && !a[0])) ? 0 : 2;
  endfunction

  function automatic logic [31:0] prom_read(logic [3:0] a, logic [1:0] sz);
    logic [31:0] v = 0;
    for (int i = 0; i < 4; i++) v[8*i +: 8] = pm[4'(a + 4'(i))];
    return v & wmask(sz);
  endfunction

  task automatic access(bit mem, logic [4:0] a, logic [1:0] sz, bit wr,
                        logic [31:0] wd, bit we, string tag);
    int k = kind(mem, a, sz, dw_mode);
    logic [31:0] exp, rr;
    req_mem = mem; req_addr = a; req_size = sz; req_write = wr;
    req_wdata = wd; prom_we = we; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    prom_we = $urandom % 2;
    if (k == 1) begin
      logic [4:0] ea = mem ? {1'b0, a[3:0]} : a;
      chk(rp_req && !done, {tag, " R9 request raised"}, {rp_req, done}, 2'b10);
      chk(rp_addr == ea && rp_size == sz && rp_write == wr && (!wr || rp_wdata == wd),
          {tag, mem ? " R8 forward fields" : " R7 forward fields"},
          {rp_addr, rp_size, rp_write, rp_wdata}, {ea, sz, wr, wd});
      repeat ($urandom % 4) begin
        @(negedge clk);
        chk(rp_req && rp_addr == ea && !done, {tag, " R9 hold"}, {rp_req, rp_addr}, {1'b1, ea});
      end
      rr = $urandom;
      rp_ready = 1; rp_rdata = rr;
      @(negedge clk);
      rp_ready = 0;
      exp = wr ? 0 : rr & wmask(sz);
      chk(done && rdata == exp && !rp_req, {tag, " R9 completion"}, {done, rdata}, {1'b1, exp});
    end else begin
      if (k == 0) exp = wr ? 0 : prom_read(a[3:0], sz);
      else exp = wr ? 0 : wmask(sz);
      chk(done && !rp_req && rdata == exp,
          {tag, k == 0 ? " R6 R10 PROM reply" : " R4 refused reply"},
          {done, rdata}, {1'b1, exp});
      if (k == 0 && wr && we)
        for (int i = 0; i < 4; i++)
          if (wmask(sz)[8*i]) pm[4'(a[3:0] + 4'(i))] = wd[8*i +: 8];
    end
  endtask

  task automatic check_all(string tag);
    bit sd = dw_mode;
    dw_mode = 0;
    for (int i = 0; i < 16; i++) access(0, 5'(i), 0, 0, 0, 0, tag);
    dw_mode = sd;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) pm[i] = DEF[8*i +: 8];
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rp_req, "R1 reset outputs", {busy, done, rp_req}, 0);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 default PROM");

    dw_mode = 0;
    access(0, 5'h03, 1, 0, 0, 0, "R2 odd halfword");
    access(0, 5'h04, 2, 0, 0, 0, "R2 word in word mode");
    access(0, 5'h06, 1, 0, 0, 0, "R2 even halfword");
    access(0, 5'h03, 1, 1, 32'h1111, 1, "R4 refused write");
    check_all("R4 after refused write");
    dw_mode = 1;
    access(0, 5'h02, 0, 0, 0, 0, "R3 byte in dw mode");
    access(0, 5'h06, 2, 0, 0, 0, "R3 misaligned word");
    access(0, 5'h08, 2, 1, 32'hA1B2C3D4, 1, "R3 R6 aligned word write");
    access(0, 5'h08, 2, 0, 0, 0, "R6 word readback");
    access(0, 5'h0C, 3, 0, 0, 0, "R4 illegal size");
    dw_mode = 0;
    access(0, 5'h05, 0, 1, 32'h77, 0, "R5 write disabled");
    check_all("R5 after disabled write");
    access(0, 5'h14, 0, 0, 0, 0, "R7 byte to registers");
    access(0, 5'h16, 1, 1, 32'hBEEF, 0, "R7 io forward");
    access(1, 5'h0F, 1, 1, 32'h5A6B, 1, "R8 R6 wrap halfword");
    access(1, 5'h0F, 2, 0, 0, 0, "R8 unaligned word");
    access(1, 5'h1A, 0, 0, 0, 0, "R8 byte to reg half");
    access(1, 5'h1A, 2, 0, 0, 0, "R8 mem forward");

    // R11: request during busy is dropped
    req_mem = 0; req_addr = 5'h10; req_size = 2; req_write = 0; req_valid = 1;
    @(negedge clk);
    chk(busy, "R11 busy raised", busy, 1);
    req_addr = 5'h01; req_size = 0; req_write = 1; req_wdata = 32'hEE; prom_we = 1;
    @(negedge clk);
    req_valid = 0; prom_we = 0;
    @(negedge clk);
    chk(busy && !done, "R11 still busy", {busy, done}, 2'b10);
    rp_ready = 1; rp_rdata = 32'h1234_5678;
    @(negedge clk);
    rp_ready = 0;
    chk(done && rdata == 32'h1234_5678, "R11 R9 forward reply", rdata, 32'h1234_5678);
    @(negedge clk);
    chk(!done && !busy, "R11 no extra completion", {done, busy}, 0);
    check_all("R11 PROM unchanged");

    for (int n = 0; n < 400; n++) begin
      dw_mode = $urandom % 2;
      access($urandom % 2, 5'($urandom), 2'($urandom), $urandom % 2, $urandom,
             $urandom % 2, "R5 random");
    end
    check_all("R5 R6 final PROM");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule